// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns one loaded start address into a short burst of up to four consecutive accesses. Each rising clock edge is either a load or a step, chosen by a single control input. On a load the block takes in a full address, the access type (read or write) and the ordering mode, provided the chip is selected. On a step it moves to the next beat of the burst. While a burst runs, only the two lowest address bits change; the upper bits and the access type stay as they were captured at the load.

Two orderings are available. Interleaved order flips low bits of the start value by exclusive-or with the beat number. Linear order counts up from the start value and wraps modulo four. A step after the fourth beat returns to the start value. A step when no burst is active, for example after a deselect, leaves every output unchanged. The block is meant to sit between a command port and a memory array. Storage and data paths belong to the surrounding logic.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `burst_valid` is 0, `op_write` is 0 and `addr_out` is all zeros.
- R2: On a rising edge with `advance`=0 and `cs`=1, the next cycle shows `addr_out` equal to `addr_in`, `burst_valid`=1 and `op_write` equal to `wr_en` (1 = write, 0 = read).
- R3: On a rising edge with `advance`=0 and `cs`=0, the next cycle shows `burst_valid`=0, with `addr_out` and `op_write` unchanged.
- R4: On a rising edge with `advance`=1 while `burst_valid`=1, the values of `cs` and `wr_en` have no effect: `burst_valid` stays 1 and `op_write` keeps its value.
- R5: With `ilv_mode`=1 at the load and start low bits s (`addr_in[1:0]`), beat k (k = 0 at the load, +1 per step) presents `addr_out[1:0]` = s XOR k. For example, s=01 gives 01, 00, 11, 10.
- R6: With `ilv_mode`=0 at the load, beat k presents `addr_out[1:0]` = (s + k) mod 4. For example, s=10 gives 10, 11, 00, 01.
- R7: During a burst, `addr_out[AW-1:2]` stays equal to the loaded upper bits.
- R8: A step after the fourth beat presents the start low bits s again, and the sequence repeats.
- R9: On a rising edge with `advance`=1 while `burst_valid`=0, `addr_out`, `op_write` and `burst_valid` are unchanged.
- R10: The ordering is fixed at the load. Changing `ilv_mode` during a burst does not change the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | 0 = load (or deselect), 1 = step the burst |
| cs | input | 1 | Chip select, active high, used only on a load edge |
| wr_en | input | 1 | Access type at load: 1 = write, 0 = read |
| ilv_mode | input | 1 | Ordering at load: 1 = interleaved, 0 = linear |
| addr_in | input | AW | Full start address |
| addr_out | output | AW | Current burst address |
| burst_valid | output | 1 | A burst is active |
| op_write | output | 1 | Held access type of the active burst |

## Verification
Two events can meet on the same edge. A step can arrive while the command inputs (`cs`, `wr_en`, `ilv_mode`) hold values that would mean a deselect or a new write/read if the edge were a load. The bench provokes this by driving these inputs to conflicting values on every step edge. Each following cycle is judged by comparing the low address bits with a sequence the bench computes itself, and by checking that the access type and the valid flag did not move. The fourth step, where the beat counter wraps, is driven the same way to show that the wrap and the ignored commands do not disturb each other.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;

  // Decode of the load/advance control for one edge.
  typedef enum logic [1:0] {
    EDGE_LOAD      = 2'd0,
    EDGE_DESELECT  = 2'd1,
    EDGE_STEP      = 2'd2,
    EDGE_IDLE_STEP = 2'd3
  } edge_kind_e;

  function automatic edge_kind_e classify_edge(input logic advance,
                                               input logic cs,
                                               input logic active);
    if (!advance) return cs ? EDGE_LOAD : EDGE_DESELECT;
    return active ? EDGE_STEP : EDGE_IDLE_STEP;
  endfunction

endpackage

// File: rtl/burst_cmd_ctrl.sv
module burst_cmd_ctrl
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          cs,
  input  logic          wr_en,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr_in,
  output logic          load_ev,
  output logic          desel_ev,
  output logic          step_ev,
  output logic          idle_step_ev,
  output logic          active,
  output logic          op_write,
  output order_e        order,
  output logic [AW-1:0] base_addr
);

  edge_kind_e kind;

  always_comb begin
    kind         = classify_edge(advance, cs, active);
    load_ev      = (kind == EDGE_LOAD);
    desel_ev     = (kind == EDGE_DESELECT);
    step_ev      = (kind == EDGE_STEP);
    idle_step_ev = (kind == EDGE_IDLE_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      op_write  <= 1'b0;
      order     <= ORD_LINEAR;
      base_addr <= '0;
    end else if (load_ev) begin
      active    <= 1'b1;
      op_write  <= wr_en;
      order     <= ilv_mode ? ORD_INTERLEAVED : ORD_LINEAR;
      base_addr <= addr_in;
    end else if (desel_ev) begin
      active    <= 1'b0;
    end
  end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          inc,
  output logic [BW-1:0] beat,
  output logic          wrap_ev
);

  localparam logic [BW-1:0] LAST_BEAT = '1;

  assign wrap_ev = inc && (beat == LAST_BEAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      beat <= '0;
    else if (clear)  beat <= '0;
    else if (inc)    beat <= beat + 1'b1;
  end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_seq_pkg::*;
#(
  parameter int BW = 2
) (
  input  logic [BW-1:0] start_lo,
  input  logic [BW-1:0] beat,
  input  order_e        order,
  output logic [BW-1:0] lo
);

  logic [BW-1:0] ilv_lo;
  logic [BW-1:0] lin_lo;

  // Interleaved: each low bit flips with the matching beat bit.
  for (genvar i = 0; i < BW; i++) begin : g_ilv
    assign ilv_lo[i] = start_lo[i] ^ beat[i];
  end

  // Linear: carry ripples upward, wraps naturally at BW bits.
  assign lin_lo = start_lo + beat;

  assign lo = (order == ORD_INTERLEAVED) ? ilv_lo : lin_lo;

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int BW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          advance,
  input  logic          cs,
  input  logic          wr_en,
  input  logic          ilv_mode,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic          burst_valid,
  output logic          op_write
);

  logic          load_ev;
  logic          desel_ev;
  logic          step_ev;
  logic          idle_step_ev;
  logic          wrap_ev;
  logic          active;
  order_e        order;
  logic [AW-1:0] base_addr;
  logic [BW-1:0] start_lo;
  logic [BW-1:0] beat;
  logic [BW-1:0] cur_lo;

  burst_cmd_ctrl #(.AW(AW)) u_cmd (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance      (advance),
    .cs           (cs),
    .wr_en        (wr_en),
    .ilv_mode     (ilv_mode),
    .addr_in      (addr_in),
    .load_ev      (load_ev),
    .desel_ev     (desel_ev),
    .step_ev      (step_ev),
    .idle_step_ev (idle_step_ev),
    .active       (active),
    .op_write     (op_write),
    .order        (order),
    .base_addr    (base_addr)
  );

  burst_beat_cnt #(.BW(BW)) u_beat (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load_ev),
    .inc     (step_ev),
    .beat    (beat),
    .wrap_ev (wrap_ev)
  );

  assign start_lo = base_addr[BW-1:0];

  burst_order_gen #(.BW(BW)) u_order (
    .start_lo (start_lo),
    .beat     (beat),
    .order    (order),
    .lo       (cur_lo)
  );

  assign addr_out    = {base_addr[AW-1:BW], cur_lo};
  assign burst_valid = active;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 20,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          advance,
  input logic          cs,
  input logic          wr_en,
  input logic [AW-1:0] addr_in,
  input logic [AW-1:0] addr_out,
  input logic          burst_valid,
  input logic          op_write,
  input logic          load_ev,
  input logic          step_ev,
  input logic          idle_step_ev,
  input logic          wrap_ev,
  input logic [BW-1:0] start_lo
);

  // R2: a selected load presents the full address and access type
  a_r2_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && cs) |=> (addr_out == $past(addr_in)) && burst_valid
                         && (op_write == $past(wr_en)));

  // R3: an unselected load ends the burst
  a_r3_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !cs) |=> !burst_valid && $stable(op_write));

  // R4: a step keeps the burst and its access type
  a_r4_hold_op: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> burst_valid && $stable(op_write));

  // R7: upper address bits do not move on a step
  a_r7_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    step_ev |=> $stable(addr_out[AW-1:BW]));

  // R8: the step after the last beat returns to the start bits
  a_r8_wrap_start: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_ev |=> addr_out[BW-1:0] == start_lo);

  // R9: a step with no burst changes nothing
  a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    idle_step_ev |=> $stable(addr_out) && $stable(op_write) && !burst_valid);

  // Exactly one edge kind on each step request
  a_r4_edge_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> $onehot({step_ev, idle_step_ev}) && !load_ev);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .BW(BW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .advance      (advance),
  .cs           (cs),
  .wr_en        (wr_en),
  .addr_in      (addr_in),
  .addr_out     (addr_out),
  .burst_valid  (burst_valid),
  .op_write     (op_write),
  .load_ev      (load_ev),
  .step_ev      (step_ev),
  .idle_step_ev (idle_step_ev),
  .wrap_ev      (wrap_ev),
  .start_lo     (start_lo)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW       = 20;
  localparam int BW       = 2;
  localparam int CLK_PER  = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          advance;
  logic          cs;
  logic          wr_en;
  logic          ilv_mode;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] addr_out;
  logic          burst_valid;
  logic          op_write;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  burst_addr_seq #(.AW(AW), .BW(BW)) i_burst_addr_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .advance     (advance),
    .cs          (cs),
    .wr_en       (wr_en),
    .ilv_mode    (ilv_mode),
    .addr_in     (addr_in),
    .addr_out    (addr_out),
    .burst_valid (burst_valid),
    .op_write    (op_write)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 time unit after the rising edge.
  task automatic cyc(input logic adv, input logic c, input logic w,
                     input logic m, input logic [AW-1:0] a);
    @(negedge clk);
    advance = adv; cs = c; wr_en = w; ilv_mode = m; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [1:0] exp_lo(input logic ilv, input logic [1:0] s,
                                        input int k);
    logic [1:0] kk;
    kk = 2'(k % 4);
    if (ilv) return s ^ kk;
    return 2'((int'(s) + int'(kk)) % 4);
  endfunction

  task automatic t_reset;
    chk("R1 valid",    32'(burst_valid), 32'd0);
    chk("R1 op_write", 32'(op_write),    32'd0);
    chk("R1 addr_out", 32'(addr_out),    32'd0);
  endtask

  // Interleaved burst; every step drives conflicting cs/wr_en.
  task automatic t_interleaved(input logic [AW-1:0] a);
    logic [AW-1:0] upper;
    upper = a & ~AW'(3);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, a);
    chk("R2 addr",  32'(addr_out),    32'(a));
    chk("R2 valid", 32'(burst_valid), 32'd1);
    chk("R2 op",    32'(op_write),    32'd0);
    for (int k = 1; k <= 5; k++) begin
      cyc(1'b1, k[0], 1'b1, 1'b1, ~a);
      chk(k == 4 ? "R8 wrap ilv" : "R5 ilv lo", 32'(addr_out[1:0]),
          32'(exp_lo(1'b1, a[1:0], k)));
      chk("R7 upper", 32'(addr_out & ~AW'(3)), 32'(upper));
      chk("R4 op held",  32'(op_write),    32'd0);
      chk("R4 valid",    32'(burst_valid), 32'd1);
    end
  endtask

  // Linear write burst; mode flips during the burst.
  task automatic t_linear(input logic [AW-1:0] a);
    cyc(1'b0, 1'b1, 1'b1, 1'b0, a);
    chk("R2 addr lin", 32'(addr_out), 32'(a));
    chk("R2 op write", 32'(op_write), 32'd1);
    for (int k = 1; k <= 4; k++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b1, '0);
      chk(k == 4 ? "R8 wrap lin" : "R6/R10 lin lo", 32'(addr_out[1:0]),
          32'(exp_lo(1'b0, a[1:0], k)));
      chk("R7 upper lin", 32'(addr_out[AW-1:2]), 32'(a[AW-1:2]));
      chk("R4 op held lin", 32'(op_write), 32'd1);
    end
  endtask

  // Deselect, then steps that must do nothing.
  task automatic t_deselect;
    logic [AW-1:0] held;
    logic          op_h;
    held = addr_out;
    op_h = op_write;
    cyc(1'b0, 1'b0, ~op_h, 1'b1, ~held);
    chk("R3 valid",    32'(burst_valid), 32'd0);
    chk("R3 addr",     32'(addr_out),    32'(held));
    chk("R3 op",       32'(op_write),    32'(op_h));
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 1'b1, ~op_h, 1'b0, ~held);
      chk("R9 addr",  32'(addr_out),    32'(held));
      chk("R9 valid", 32'(burst_valid), 32'd0);
      chk("R9 op",    32'(op_write),    32'(op_h));
    end
  endtask

  initial begin
    rst_n = 1'b0; advance = 1'b0; cs = 1'b0; wr_en = 1'b0;
    ilv_mode = 1'b1; addr_in = '0;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_interleaved(20'hABCD1);
    t_interleaved(20'h12340);
    t_linear(20'h5A5A6);
    t_linear(20'h00003);
    t_deselect();
    t_interleaved(20'hFFFF2);
    t_deselect();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule